// File: doc/BRIEF.md
# Dual-Byte Line Driver with Boundary Scan

This block is a non-inverting buffer for two independent 9-bit bytes, A and B. Each byte has its own three-state output, shown as a data vector plus a per-bit drive flag. A byte is driven only while both of its active-low enable pins are low. If either pin is high, every bit of that byte floats.

A 42-cell boundary-scan register sits around the buffer and is run by the strobes of an external test access port controller. Observe-only cells sit on the data inputs and the four enable pins. Observe-and-control cells, each with its own update stage, sit on the eighteen outputs and on the two internal active-high byte enables. A 3-bit mode code selects among five behaviours: normal operation with the boundary register in the serial path (sample/preload), external test, clamp, forced high impedance and bypass. A synchronous test-logic reset puts the outputs back on the system path.

Top module: `dual_byte_scan_driver`

## Requirements
- R1: With mode code 0 (sample/preload) and no reset, `a_out` equals `a_in` and `b_out` equals `b_in`, bit for bit, with no inversion. Each drive flag of a byte is 1 when both of that byte's enable pins are low.
- R2: In the system-path modes (codes 0 and 4 to 7), if either enable pin of a byte is high, all nine drive flags of that byte are 0. The other byte is not affected.
- R3: In modes 0 and 1, a `capture_dr` edge loads the chain. The order, from bit 41 down to bit 0, is: A enable pin 1 (`a_en_n[1]`), A enable pin 2 (`a_en_n[0]`), the internal A enable (1 when both A pins are low), B pin 1, B pin 2, the internal B enable, A inputs 0..8, B inputs 0..8, A outputs 0..8 (each capturing its system value `a_in`), and B outputs 0..8.
- R4: In modes 0 and 1, a `shift_dr` edge moves the chain one place toward bit 0, with `tdi` entering bit 41. `tdo` shows bit 0.
- R5: The update stages of the control cells load only on an `update_dr` edge in mode 0 or 1, and they keep their value while the chain shifts.
- R6: In mode 1 (external test), `a_out`/`b_out` take the update values of the A/B output cells. All drive flags of a byte equal the update value of that byte's internal enable cell.
- R7: In mode 2 (clamp), the outputs and drive flags come from the update stages as in R6. The serial path is the one-bit bypass stage, and `update_dr` has no effect on the outputs.
- R8: In mode 3 (high impedance), all eighteen drive flags are 0 whatever the enable pins are. The serial path is the bypass stage.
- R9: When the bypass stage is in the path (codes 2 to 7), a `capture_dr` edge loads 0 into it, and a `shift_dr` edge loads `tdi`, so `tdo` repeats `tdi` one cycle later.
- R10: While `rst` is high, the outputs follow the system path of R1 and R2 in any mode. Reset clears the chain, the update stages and the bypass stage, so after reset, external test drives zero data with all drive flags 0.
- R11: Mode codes 4 to 7 (bypass) behave like R1 and R2 at the outputs and select the bypass stage as the serial path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high test-logic reset |
| a_in | input | 9 | Byte A data inputs |
| a_en_n | input | 2 | Byte A active-low enable pins ([1] = first, [0] = second) |
| a_out | output | 9 | Byte A output data |
| a_drv | output | 9 | Byte A per-bit drive flags (0 = high impedance) |
| b_in | input | 9 | Byte B data inputs |
| b_en_n | input | 2 | Byte B active-low enable pins ([1] = first, [0] = second) |
| b_out | output | 9 | Byte B output data |
| b_drv | output | 9 | Byte B per-bit drive flags |
| mode_sel | input | 3 | 0 sample/preload, 1 external test, 2 clamp, 3 high impedance, 4-7 bypass |
| capture_dr | input | 1 | Capture strobe for the selected data register |
| shift_dr | input | 1 | Shift strobe for the selected data register |
| update_dr | input | 1 | Update strobe for the boundary register |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |

## Verification
The assertions check four things on every cycle: the transparent data path in sample mode, the byte-wide disable whenever an enable pin is high, the all-off outputs in high-impedance mode, and the hold of external-test outputs on every cycle without an update strobe. They also check the bypass stage's zero capture and its one-cycle echo of `tdi`. Only the bench scenarios can show that the chain order is right. They do this by shifting out a captured vector and comparing all 42 positions, and by preloading a vector whose bits land on the intended output cells. The scenarios also show that clamp keeps those values while the bypass stage shifts and that reset clears the update stages.

// File: rtl/dbsd_pkg.sv
package dbsd_pkg;

  typedef enum logic [2:0] {
    MODE_SAMPLE = 3'd0,
    MODE_EXTEST = 3'd1,
    MODE_CLAMP  = 3'd2,
    MODE_HIGHZ  = 3'd3,
    MODE_BYPASS = 3'd4
  } scan_mode_e;

  typedef struct packed {
    logic use_upd;    // outputs come from control-cell update stages
    logic force_off;  // every drive flag low
    logic bsr_sel;    // boundary register is the serial path
  } path_ctl_t;

  function automatic path_ctl_t decode_mode(input logic [2:0] code, input logic rst);
    path_ctl_t c;
    c = '{use_upd: 1'b0, force_off: 1'b0, bsr_sel: 1'b0};
    if (rst) begin
      c.bsr_sel = 1'b1;
    end else begin
      case (code)
        MODE_SAMPLE: c.bsr_sel = 1'b1;
        MODE_EXTEST: begin c.bsr_sel = 1'b1; c.use_upd = 1'b1; end
        MODE_CLAMP:  c.use_upd = 1'b1;
        MODE_HIGHZ:  c.force_off = 1'b1;
        default:     c = '{use_upd: 1'b0, force_off: 1'b0, bsr_sel: 1'b0};
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/dbsd_bsr.sv
module dbsd_bsr #(
  parameter int BYTE_W = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sel,
  input  logic                  shift_en,
  input  logic                  capture_en,
  input  logic                  update_en,
  input  logic                  tdi,
  input  logic [4*BYTE_W+5:0]   cap_vec,
  output logic                  so,
  output logic [BYTE_W-1:0]     a_upd,
  output logic [BYTE_W-1:0]     b_upd,
  output logic                  a_en_upd,
  output logic                  b_en_upd
);
  localparam int LEN      = 4*BYTE_W + 6;
  localparam int BO_TOP   = BYTE_W - 1;     // output B bit 0 cell
  localparam int AO_TOP   = 2*BYTE_W - 1;   // output A bit 0 cell
  localparam int BEN_IDX  = 4*BYTE_W;       // internal B enable cell
  localparam int AEN_IDX  = 4*BYTE_W + 3;   // internal A enable cell

  logic [LEN-1:0] sr_q;
  logic           upd_fire;

  assign upd_fire = sel && update_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (sel && capture_en) begin
      sr_q <= cap_vec;
    end else if (sel && shift_en) begin
      sr_q <= {tdi, sr_q[LEN-1:1]};
    end
  end

  assign so = sr_q[0];

  // update stages exist only behind the control cells
  for (genvar k = 0; k < BYTE_W; k++) begin : g_out_upd
    always_ff @(posedge clk) begin
      if (rst) begin
        a_upd[k] <= 1'b0;
        b_upd[k] <= 1'b0;
      end else if (upd_fire) begin
        a_upd[k] <= sr_q[AO_TOP-k];
        b_upd[k] <= sr_q[BO_TOP-k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_en_upd <= 1'b0;
      b_en_upd <= 1'b0;
    end else if (upd_fire) begin
      a_en_upd <= sr_q[AEN_IDX];
      b_en_upd <= sr_q[BEN_IDX];
    end
  end

endmodule

// File: rtl/dbsd_bypass.sv
module dbsd_bypass (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic shift_en,
  input  logic capture_en,
  input  logic tdi,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (sel && capture_en) begin
      q <= 1'b0;
    end else if (sel && shift_en) begin
      q <= tdi;
    end
  end
endmodule

// File: rtl/dbsd_byte_out.sv
module dbsd_byte_out #(
  parameter int BYTE_W = 9
) (
  input  logic [BYTE_W-1:0] sys_data,
  input  logic [1:0]        en_n,
  input  logic [BYTE_W-1:0] upd_data,
  input  logic              upd_en,
  input  logic              use_upd,
  input  logic              force_off,
  output logic [BYTE_W-1:0] dout,
  output logic [BYTE_W-1:0] drv,
  output logic              sys_en
);
  logic eff_en;

  assign sys_en = ~|en_n;

  always_comb begin
    if (force_off)    eff_en = 1'b0;
    else if (use_upd) eff_en = upd_en;
    else              eff_en = sys_en;
  end

  for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
    assign dout[k] = use_upd ? upd_data[k] : sys_data[k];
    assign drv[k]  = eff_en;
  end
endmodule

// File: rtl/dual_byte_scan_driver.sv
module dual_byte_scan_driver #(
  parameter int BYTE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] a_in,
  input  logic [1:0]        a_en_n,
  output logic [BYTE_W-1:0] a_out,
  output logic [BYTE_W-1:0] a_drv,
  input  logic [BYTE_W-1:0] b_in,
  input  logic [1:0]        b_en_n,
  output logic [BYTE_W-1:0] b_out,
  output logic [BYTE_W-1:0] b_drv,
  input  logic [2:0]        mode_sel,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo
);
  import dbsd_pkg::*;

  localparam int LEN = 4*BYTE_W + 6;

  path_ctl_t          ctl;
  logic [BYTE_W-1:0]  a_rev, b_rev;
  logic [BYTE_W-1:0]  a_upd, b_upd;
  logic               a_en_upd, b_en_upd;
  logic               a_sys_en, b_sys_en;
  logic [LEN-1:0]     cap_vec;
  logic               bsr_so, byp_q;

  assign ctl = decode_mode(mode_sel, rst);

  // bit 0 of each byte sits nearest the top of its chain field
  for (genvar k = 0; k < BYTE_W; k++) begin : g_rev
    assign a_rev[k] = a_in[BYTE_W-1-k];
    assign b_rev[k] = b_in[BYTE_W-1-k];
  end

  assign cap_vec = {a_en_n[1], a_en_n[0], a_sys_en,
                    b_en_n[1], b_en_n[0], b_sys_en,
                    a_rev, b_rev, a_rev, b_rev};

  dbsd_byte_out #(.BYTE_W(BYTE_W)) a_byte_i (
    .sys_data (a_in),
    .en_n     (a_en_n),
    .upd_data (a_upd),
    .upd_en   (a_en_upd),
    .use_upd  (ctl.use_upd),
    .force_off(ctl.force_off),
    .dout     (a_out),
    .drv      (a_drv),
    .sys_en   (a_sys_en)
  );

  dbsd_byte_out #(.BYTE_W(BYTE_W)) b_byte_i (
    .sys_data (b_in),
    .en_n     (b_en_n),
    .upd_data (b_upd),
    .upd_en   (b_en_upd),
    .use_upd  (ctl.use_upd),
    .force_off(ctl.force_off),
    .dout     (b_out),
    .drv      (b_drv),
    .sys_en   (b_sys_en)
  );

  dbsd_bsr #(.BYTE_W(BYTE_W)) bsr_i (
    .clk       (clk),
    .rst       (rst),
    .sel       (ctl.bsr_sel),
    .shift_en  (shift_dr),
    .capture_en(capture_dr),
    .update_en (update_dr),
    .tdi       (tdi),
    .cap_vec   (cap_vec),
    .so        (bsr_so),
    .a_upd     (a_upd),
    .b_upd     (b_upd),
    .a_en_upd  (a_en_upd),
    .b_en_upd  (b_en_upd)
  );

  dbsd_bypass byp_i (
    .clk       (clk),
    .rst       (rst),
    .sel       (~ctl.bsr_sel),
    .shift_en  (shift_dr),
    .capture_en(capture_dr),
    .tdi       (tdi),
    .q         (byp_q)
  );

  assign tdo = ctl.bsr_sel ? bsr_so : byp_q;

endmodule

// File: rtl/dbsd_checker.sv
module dbsd_checker #(
  parameter int BYTE_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        mode_sel,
  input logic              capture_dr,
  input logic              shift_dr,
  input logic              update_dr,
  input logic              tdi,
  input logic              tdo,
  input logic [BYTE_W-1:0] a_in,
  input logic [BYTE_W-1:0] b_in,
  input logic [1:0]        a_en_n,
  input logic [1:0]        b_en_n,
  input logic [BYTE_W-1:0] a_out,
  input logic [BYTE_W-1:0] b_out,
  input logic [BYTE_W-1:0] a_drv,
  input logic [BYTE_W-1:0] b_drv
);
  logic byp_path, sys_path;
  assign byp_path = (mode_sel >= 3'd2);
  assign sys_path = (mode_sel == 3'd0) || (mode_sel >= 3'd4);

  AST_SAMPLE_PASS: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 3'd0) |-> (a_out == a_in && b_out == b_in)); // R1

  AST_BYTE_DISABLE: assert property (@(posedge clk) disable iff (rst)
    sys_path |-> ((a_en_n == 2'b00 || a_drv == '0) && (b_en_n == 2'b00 || b_drv == '0))); // R2

  AST_HIGHZ_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 3'd3) |-> (a_drv == '0 && b_drv == '0)); // R8

  AST_EXTEST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 3'd1 && !update_dr) |=>
      (mode_sel != 3'd1 || ($stable(a_out) && $stable(b_out) && $stable(a_drv) && $stable(b_drv)))); // R5

  AST_BYP_CAPTURE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (byp_path && capture_dr) |=> (!byp_path || tdo == 1'b0)); // R9

  AST_BYP_ECHO: assert property (@(posedge clk) disable iff (rst)
    (byp_path && shift_dr && !capture_dr) |=> (!byp_path || tdo == $past(tdi))); // R9
endmodule

bind dual_byte_scan_driver dbsd_checker #(.BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst(rst), .mode_sel(mode_sel), .capture_dr(capture_dr),
  .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
  .a_in(a_in), .b_in(b_in), .a_en_n(a_en_n), .b_en_n(b_en_n),
  .a_out(a_out), .b_out(b_out), .a_drv(a_drv), .b_drv(b_drv)
);

// File: tb/dual_byte_scan_driver_tb.sv
`timescale 1ns/1ps
module dual_byte_scan_driver_tb_top;
  localparam int W = 9;
  localparam int L = 42;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [1:0] a_en_n = 2'b00, b_en_n = 2'b00;
  logic [2:0] mode_sel = 3'd0;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic [W-1:0] a_out, a_drv, b_out, b_drv;
  logic tdo;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dual_byte_scan_driver #(.BYTE_W(W)) dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .a_en_n(a_en_n), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_en_n(b_en_n), .b_out(b_out), .b_drv(b_drv), .mode_sel(mode_sel),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rev(input logic [W-1:0] v);
    for (int i = 0; i < W; i++) rev[i] = v[W-1-i];
  endfunction

  // chain image built from the stated order, bit 41 first
  function automatic logic [L-1:0] chain_img(input logic [W-1:0] ai, input logic [W-1:0] bi,
                                             input logic [1:0] aen, input logic [1:0] ben);
    return {aen[1], aen[0], (aen == 2'b00), ben[1], ben[0], (ben == 2'b00),
            rev(ai), rev(bi), rev(ai), rev(bi)};
  endfunction

  function automatic logic [L-1:0] ctl_img(input logic aen_int, input logic [W-1:0] ao,
                                           input logic ben_int, input logic [W-1:0] bo);
    return {2'b00, aen_int, 2'b00, ben_int, {W{1'b0}}, {W{1'b0}}, rev(ao), rev(bo)};
  endfunction

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic pulse_capture();
    @(negedge clk); capture_dr = 1'b1;
    @(negedge clk); capture_dr = 1'b0;
  endtask

  task automatic pulse_update();
    @(negedge clk); update_dr = 1'b1;
    @(negedge clk); update_dr = 1'b0;
  endtask

  task automatic shift_vec(input logic [L-1:0] din, output logic [L-1:0] dout);
    for (int i = 0; i < L; i++) begin
      @(negedge clk); shift_dr = 1'b1; tdi = din[i];
      #1 dout[i] = tdo;
    end
    @(negedge clk); shift_dr = 1'b0;
  endtask

  task automatic bypass_walk(input logic [7:0] pat, input string req);
    @(negedge clk); shift_dr = 1'b1; tdi = pat[0];
    for (int i = 1; i < 8; i++) begin
      @(negedge clk); tdi = pat[i];
      #1 check(req, tdo, pat[i-1]);
    end
    @(negedge clk); shift_dr = 1'b0;
    #1 check(req, tdo, pat[7]);
  endtask

  task automatic t_reset();
    mode_sel = 3'd1; a_in = 9'h1FF; b_in = 9'h0C3;
    settle();
    check("R10 reset a_out", a_out, 9'h1FF);
    check("R10 reset a_drv", a_drv, 9'h1FF);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R10 post-reset extest a_drv", a_drv, 0);
    check("R10 post-reset extest b_drv", b_drv, 0);
    check("R10 post-reset extest a_out", a_out, 0);
    mode_sel = 3'd0;
  endtask

  task automatic t_normal();
    @(negedge clk); mode_sel = 3'd0; a_in = 9'h1A5; b_in = 9'h05A; a_en_n = 2'b00; b_en_n = 2'b00;
    #1;
    check("R1 a_out", a_out, 9'h1A5);
    check("R1 b_out", b_out, 9'h05A);
    check("R1 a_drv", a_drv, 9'h1FF);
    check("R1 b_drv", b_drv, 9'h1FF);
    @(negedge clk); a_en_n = 2'b01; #1;
    check("R2 a off pin2", a_drv, 0);
    check("R2 b unaffected", b_drv, 9'h1FF);
    @(negedge clk); a_en_n = 2'b10; b_en_n = 2'b11; #1;
    check("R2 a off pin1", a_drv, 0);
    check("R2 b off both", b_drv, 0);
    check("R1 data still passes", a_out, 9'h1A5);
    @(negedge clk); a_en_n = 2'b00; b_en_n = 2'b00;
  endtask

  task automatic t_capture(input logic [W-1:0] ai, input logic [W-1:0] bi,
                           input logic [1:0] aen, input logic [1:0] ben);
    logic [L-1:0] got;
    @(negedge clk); mode_sel = 3'd0; a_in = ai; b_in = bi; a_en_n = aen; b_en_n = ben;
    pulse_capture();
    shift_vec('0, got);
    check("R3 R4 captured chain", got, chain_img(ai, bi, aen, ben));
  endtask

  task automatic t_extest();
    logic [L-1:0] junk;
    @(negedge clk); mode_sel = 3'd0; a_en_n = 2'b00; b_en_n = 2'b00;
    shift_vec(ctl_img(1'b1, 9'h155, 1'b0, 9'h0AA), junk);
    pulse_update();
    @(negedge clk); mode_sel = 3'd1; a_in = 9'h000; b_in = 9'h1FF; #1;
    check("R6 extest a_out", a_out, 9'h155);
    check("R6 extest a_drv", a_drv, 9'h1FF);
    check("R6 extest b_out", b_out, 9'h0AA);
    check("R6 extest b_drv", b_drv, 0);
    shift_vec(ctl_img(1'b0, 9'h0F0, 1'b1, 9'h133), junk);
    #1;
    check("R5 hold while shifting a_out", a_out, 9'h155);
    check("R5 hold while shifting b_drv", b_drv, 0);
    pulse_update();
    #1;
    check("R4 R6 new a_out", a_out, 9'h0F0);
    check("R6 new a_drv", a_drv, 0);
    check("R4 R6 new b_out", b_out, 9'h133);
    check("R6 new b_drv", b_drv, 9'h1FF);
  endtask

  task automatic t_clamp();
    @(negedge clk); mode_sel = 3'd2; a_in = 9'h1FF; #1;
    check("R7 clamp a_out", a_out, 9'h0F0);
    check("R7 clamp b_out", b_out, 9'h133);
    check("R7 clamp b_drv", b_drv, 9'h1FF);
    bypass_walk(8'b1011_0010, "R7 clamp bypass path");
    @(negedge clk); shift_dr = 1'b1; tdi = 1'b1;
    @(negedge clk); shift_dr = 1'b0; #1;
    check("R9 bypass holds 1", tdo, 1);
    pulse_capture(); #1;
    check("R9 bypass capture zero", tdo, 0);
    pulse_update(); #1;
    check("R7 update ignored a_out", a_out, 9'h0F0);
    check("R7 update ignored a_drv", a_drv, 0);
  endtask

  task automatic t_highz();
    @(negedge clk); mode_sel = 3'd3; a_en_n = 2'b00; b_en_n = 2'b00; #1;
    check("R8 highz a_drv", a_drv, 0);
    check("R8 highz b_drv", b_drv, 0);
    bypass_walk(8'b0110_1101, "R8 highz bypass path");
  endtask

  task automatic t_bypass(input logic [2:0] code);
    @(negedge clk); mode_sel = code; a_in = 9'h0E1; b_in = 9'h11E; a_en_n = 2'b00; b_en_n = 2'b01; #1;
    check("R11 bypass a_out", a_out, 9'h0E1);
    check("R11 bypass a_drv", a_drv, 9'h1FF);
    check("R11 R2 bypass b_drv", b_drv, 0);
    bypass_walk(8'b1100_0101, "R11 bypass path");
    @(negedge clk); shift_dr = 1'b1; tdi = 1'b1;
    @(negedge clk); shift_dr = 1'b0;
    pulse_capture(); #1;
    check("R9 bypass capture zero", tdo, 0);
    @(negedge clk); b_en_n = 2'b00;
  endtask

  task automatic t_reset_again();
    @(negedge clk); mode_sel = 3'd1; rst = 1'b1; a_in = 9'h07C; a_en_n = 2'b00; #1;
    check("R10 reset overrides extest a_out", a_out, 9'h07C);
    check("R10 reset overrides extest a_drv", a_drv, 9'h1FF);
    @(negedge clk); rst = 1'b0; #1;
    check("R10 update cleared a_out", a_out, 0);
    check("R10 update cleared b_drv", b_drv, 0);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_capture(9'h1A5, 9'h05A, 2'b00, 2'b10);
    t_capture(9'h031, 9'h1CE, 2'b01, 2'b00);
    t_extest();
    t_clamp();
    t_highz();
    t_bypass(3'd4);
    t_bypass(3'd7);
    t_reset_again();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule